// File: doc/BRIEF.md
# Inter-Stage Dependency Token Controller

This block orders the work of a four-stage accelerator pipeline without a global scoreboard. The stages are, in pipeline order: load (stage 0, brings weights and inputs into the buffers), GEMM (stage 1), ALU (stage 2, activation and normalisation) and store (stage 3). Each stage runs on its own timeline. Global ordering between stages comes only from tokens passed across each of the three boundaries between neighbouring stages.

Every boundary has two token counters. The forward counter carries "data ready" tokens downstream. The backward counter carries "buffer free" tokens upstream. Each instruction presented to a stage carries four flag bits that say which neighbouring counters it consumes when it starts and which it fills when it finishes.

Each stage asks for permission to issue. A request is granted only when every token it must take is present. At most one instruction is in flight per stage, and the stage's completion strobe releases the tokens that instruction promised. An instruction with no work of its own can be used purely to move tokens, for example flags 0110 on the ALU stage.

Top module: `dep_token_ctrl`

## Requirements
- R1: After synchronous active-low reset, all six token counters read zero and no stage has an instruction in flight.
- R2: The flag nibble of stage s sits at `req_flags[4s+3:4s]`. Bit 3 is pop-previous, bit 2 is push-previous, bit 1 is pop-next and bit 0 is push-next. Forward counter b (bits `[4b+3:4b]` of `fwd_count`) is filled by stage b's push-next and drained by stage b+1's pop-previous.
- R3: A request is stalled (grant low) while any counter it pops is zero.
- R4: Pops take effect at the clock edge where the grant is high, so the popped counter is one lower in the following cycle.
- R5: Pushes take effect at the clock edge of the stage's completion strobe, using the flags latched at grant. A grant alone changes no pushed counter.
- R6: Backward counter b (bits `[4b+3:4b]` of `bwd_count`) is filled by stage b+1's push-previous and drained by stage b's pop-next.
- R7: Pop-previous and push-previous on the load stage, and pop-next and push-next on the store stage, are ignored. They neither stall nor change any counter.
- R8: Each counter saturates at 15. A push at 15 without a pop leaves 15.
- R9: A push and a pop landing on the same counter in the same cycle leave its value unchanged.
- R10: A stage with an instruction in flight is not granted again until its completion strobe. A completion strobe on an idle stage has no effect.
- R11: One instruction may pop on one boundary and push on the other. The ALU with flags 0110 takes a backward token from the store boundary and, at completion, gives a backward token to GEMM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 4 | Per-stage issue request, bit s for stage s |
| req_flags | input | 16 | Per-stage dependency flags, nibble s for stage s |
| grant | output | 4 | Per-stage issue grant (combinational, same cycle as request) |
| done | input | 4 | Per-stage completion strobe of the in-flight instruction |
| fwd_count | output | 12 | Forward token counters, nibble b for boundary b |
| bwd_count | output | 12 | Backward token counters, nibble b for boundary b |

## Verification
The bench first runs a plain load-to-GEMM handshake. Here the GEMM request waits while its counter is empty and is released one cycle after the load completes, which separates grant-time pops from completion-time pushes. Reload patterns using backward tokens (0100 followed by 0011) show whether the two directions of a boundary are wired to the right stages. Flags pointing past the pipeline ends and a same-cycle push and pop, both at a mid value and at the saturation value, show whether edge masking, saturation and the hold rule are applied. Repeated requests to a busy stage, and stray completion strobes, show the one-in-flight rule.

// File: rtl/dtc_pkg.sv
// Package: shared constants for the dependency token controller.
// Assumes four pipeline stages and a four-bit flag nibble per instruction.
package dtc_pkg;
    localparam int FLAG_W   = 4;
    localparam int F_POP_P  = 3;   // take token from previous-stage boundary
    localparam int F_PUSH_P = 2;   // give token to previous-stage boundary
    localparam int F_POP_N  = 1;   // take token from next-stage boundary
    localparam int F_PUSH_N = 0;   // give token to next-stage boundary

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_GEMM  = 2'd1,
        ST_ALU   = 2'd2,
        ST_STORE = 2'd3
    } stage_e;
endpackage

// File: rtl/dtc_token_cnt.sv
// Module: one saturating token counter between two neighbouring stages.
// Assumes at most one increment source and one decrement source, and that
// decrement is only requested while the counter is non-zero.
module dtc_token_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Apply push/pop with saturation; a simultaneous push and pop cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (inc && !dec && value != CNT_MAX) begin
            value <= value + 1'b1;
        end else if (dec && !inc) begin
            value <= value - 1'b1;
        end
    end

    // R3: a pop is never applied to an empty counter
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> value != '0);

    // R2: a lone push below the top raises the count by exactly one
    p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && value != CNT_MAX) |=> value == $past(value) + 1'b1);

    // R8: a lone push at the top keeps the maximum
    p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && value == CNT_MAX) |=> value == CNT_MAX);

    // R9: simultaneous push and pop leave the count unchanged
    p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(value));
endmodule

// File: rtl/dtc_stage_slot.sv
// Module: per-stage issue slot. Grants a request when the slot is idle and
// every counter it pops holds a token, latches the push flags, and fires the
// pushes on the completion strobe. Flags toward a missing neighbour are masked.
// Assumes done is only meaningful while an instruction is in flight.
module dtc_stage_slot
    import dtc_pkg::*;
#(
    parameter bit HAS_PREV = 1'b1,
    parameter bit HAS_NEXT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [FLAG_W-1:0] req_flags,
    input  logic              done,
    input  logic              prev_nz,
    input  logic              next_nz,
    output logic              grant,
    output logic              pop_prev,
    output logic              pop_next,
    output logic              push_prev,
    output logic              push_next
);
    logic busy;
    logic pend_push_prev;
    logic pend_push_next;
    logic need_prev;
    logic need_next;
    logic finish;

    // Decide which pops apply and whether tokens are present.
    always_comb begin
        need_prev = HAS_PREV && req_flags[F_POP_P];
        need_next = HAS_NEXT && req_flags[F_POP_N];
        grant     = req_valid && !busy
                    && (!need_prev || prev_nz)
                    && (!need_next || next_nz);
        pop_prev  = grant && need_prev;
        pop_next  = grant && need_next;
        finish    = done && busy;
        push_prev = finish && pend_push_prev;
        push_next = finish && pend_push_next;
    end

    // Track the in-flight instruction and its pending pushes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy           <= 1'b0;
            pend_push_prev <= 1'b0;
            pend_push_next <= 1'b0;
        end else if (grant) begin
            busy           <= 1'b1;
            pend_push_prev <= HAS_PREV && req_flags[F_PUSH_P];
            pend_push_next <= HAS_NEXT && req_flags[F_PUSH_N];
        end else if (finish) begin
            busy           <= 1'b0;
            pend_push_prev <= 1'b0;
            pend_push_next <= 1'b0;
        end
    end

    // R10: a granted stage cannot be granted again in the next cycle
    p_single_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !grant);

    // R5: pushes only fire together with a completion strobe
    p_push_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_prev || push_next) |-> done);
endmodule

// File: rtl/dep_token_ctrl.sv
// Module: top of the inter-stage dependency token controller. Instantiates
// one issue slot per stage and a forward and backward token counter per
// boundary, and wires each slot's pops/pushes to its neighbours' counters.
// Assumes stage 0 is load and the last stage is store.
module dep_token_ctrl
    import dtc_pkg::*;
#(
    parameter int NSTAGE = 4,
    parameter int CNT_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSTAGE-1:0]           req_valid,
    input  logic [NSTAGE*FLAG_W-1:0]    req_flags,
    output logic [NSTAGE-1:0]           grant,
    input  logic [NSTAGE-1:0]           done,
    output logic [(NSTAGE-1)*CNT_W-1:0] fwd_count,
    output logic [(NSTAGE-1)*CNT_W-1:0] bwd_count
);
    localparam int NBOUND = NSTAGE - 1;

    logic [NSTAGE-1:0] pop_prev, pop_next, push_prev, push_next;
    logic [NSTAGE-1:0] prev_nz, next_nz;
    logic [NBOUND-1:0] fwd_nz, bwd_nz;

    // Token counters: forward and backward per boundary.
    for (genvar b = 0; b < NBOUND; b++) begin : g_bound
        dtc_token_cnt #(.CNT_W(CNT_W)) u_fwd (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (push_next[b]),
            .dec   (pop_prev[b+1]),
            .value (fwd_count[b*CNT_W +: CNT_W])
        );
        dtc_token_cnt #(.CNT_W(CNT_W)) u_bwd (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (push_prev[b+1]),
            .dec   (pop_next[b]),
            .value (bwd_count[b*CNT_W +: CNT_W])
        );
        assign fwd_nz[b] = |fwd_count[b*CNT_W +: CNT_W];
        assign bwd_nz[b] = |bwd_count[b*CNT_W +: CNT_W];
    end

    // Issue slots: the neighbour-availability taps depend on stage position.
    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        if (s == 0) begin : g_first
            assign prev_nz[s] = 1'b0;
        end else begin : g_mid_p
            assign prev_nz[s] = fwd_nz[s-1];
        end
        if (s == NSTAGE - 1) begin : g_last
            assign next_nz[s] = 1'b0;
        end else begin : g_mid_n
            assign next_nz[s] = bwd_nz[s];
        end

        dtc_stage_slot #(
            .HAS_PREV (s != 0),
            .HAS_NEXT (s != NSTAGE - 1)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_valid (req_valid[s]),
            .req_flags (req_flags[s*FLAG_W +: FLAG_W]),
            .done      (done[s]),
            .prev_nz   (prev_nz[s]),
            .next_nz   (next_nz[s]),
            .grant     (grant[s]),
            .pop_prev  (pop_prev[s]),
            .pop_next  (pop_next[s]),
            .push_prev (push_prev[s]),
            .push_next (push_next[s])
        );
    end

    // R7: no token traffic toward a stage beyond either pipeline end
    p_edge_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_prev[0] || push_prev[0] || pop_next[NSTAGE-1] || push_next[NSTAGE-1]));

    // R1: counters come out of reset empty
    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> (fwd_count == '0 && bwd_count == '0));
endmodule

// File: tb/dep_token_ctrl_bench.sv
// Bench: a driver task predicts grants and counter values from the
// requirements and queues the expected counters; a monitor compares them.
module dep_token_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_valid = '0;
    logic [15:0] req_flags = '0;
    logic [3:0]  done = '0;
    logic [3:0]  grant;
    logic [11:0] fwd_count, bwd_count;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [23:0] exp_q[$];
    string       tag_q[$];

    int         mf[3];
    int         mb[3];
    bit         mbusy[4];
    logic [3:0] mfl[4];

    always #5 clk = ~clk;

    dep_token_ctrl u_dep_token_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_flags(req_flags),
        .grant(grant), .done(done), .fwd_count(fwd_count), .bwd_count(bwd_count)
    );

    // Drive one cycle, check the grant, predict the counters after the edge.
    task automatic step(input logic [3:0] v, input logic [15:0] f,
                        input logic [3:0] d, input string tag);
        logic [3:0] eg;
        logic [3:0] fl[4];
        logic [23:0] snap;
        int inc, dec;
        @(negedge clk);
        req_valid = v; req_flags = f; done = d;
        #1;
        for (int s = 0; s < 4; s++) begin
            fl[s] = f[s*4 +: 4];
            eg[s] = v[s] && !mbusy[s]
                    && (s == 0 || !fl[s][3] || mf[s-1] != 0)
                    && (s == 3 || !fl[s][1] || mb[s] != 0);
        end
        checks++;
        if (grant !== eg) begin
            errors++;
            $display("FAIL %s grant: actual %b expected %b", tag, grant, eg);
        end
        for (int b = 0; b < 3; b++) begin
            inc = (d[b] && mbusy[b] && mfl[b][0]) ? 1 : 0;
            dec = (eg[b+1] && fl[b+1][3]) ? 1 : 0;
            if (inc == 1 && dec == 0 && mf[b] < 15) mf[b]++;
            else if (dec == 1 && inc == 0) mf[b]--;
            inc = (d[b+1] && mbusy[b+1] && mfl[b+1][2]) ? 1 : 0;
            dec = (eg[b] && fl[b][1]) ? 1 : 0;
            if (inc == 1 && dec == 0 && mb[b] < 15) mb[b]++;
            else if (dec == 1 && inc == 0) mb[b]--;
        end
        for (int s = 0; s < 4; s++) begin
            if (eg[s]) begin mbusy[s] = 1'b1; mfl[s] = fl[s]; end
            else if (d[s] && mbusy[s]) mbusy[s] = 1'b0;
        end
        for (int b = 0; b < 3; b++) begin
            snap[b*4 +: 4]      = 4'(mf[b]);
            snap[12 + b*4 +: 4] = 4'(mb[b]);
        end
        exp_q.push_back(snap);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare registered counters one edge after each prediction.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({bwd_count, fwd_count} !== e) begin
                    errors++;
                    $display("FAIL %s counters: actual fwd=%h bwd=%h expected fwd=%h bwd=%h",
                             t, fwd_count, bwd_count, e[11:0], e[23:12]);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) begin mf[i] = 0; mb[i] = 0; end
        for (int i = 0; i < 4; i++) begin mbusy[i] = 1'b0; mfl[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, nothing requested
        step(4'b0000, 16'h0000, 4'b0000, "R1");
        step(4'b0000, 16'h0000, 4'b0000, "R1");
        // R3: GEMM pop-previous (1000) stalls on an empty forward counter
        step(4'b0010, 16'h0080, 4'b0000, "R3");
        step(4'b0010, 16'h0080, 4'b0000, "R3");
        // R2/R5: load push-next (0001) granted; no token until completion
        step(4'b0011, 16'h0081, 4'b0000, "R2");
        step(4'b0010, 16'h0080, 4'b0000, "R5");
        step(4'b0010, 16'h0080, 4'b0001, "R2");
        // R4: GEMM now granted, pop lands at this edge
        step(4'b0010, 16'h0080, 4'b0000, "R4");
        step(4'b0000, 16'h0000, 4'b0010, "R5");
        // R6: GEMM push-previous (0100), then load reload 0011
        step(4'b0010, 16'h0040, 4'b0000, "R6");
        step(4'b0000, 16'h0000, 4'b0010, "R6");
        step(4'b0001, 16'h0003, 4'b0000, "R6");
        step(4'b0000, 16'h0000, 4'b0001, "R6");
        // R3: load pop-next stalls with backward counter empty
        step(4'b0001, 16'h0002, 4'b0000, "R3");
        step(4'b0001, 16'h0002, 4'b0000, "R3");
        // R9: load completes (push) while GEMM pops the same counter
        step(4'b0001, 16'h0001, 4'b0000, "R9");
        step(4'b0010, 16'h0080, 4'b0001, "R9");
        step(4'b0000, 16'h0000, 4'b0010, "R9");
        // R7: load pop-previous and store push-next/pop-next are ignored
        step(4'b0001, 16'h000C, 4'b0000, "R7");
        step(4'b0000, 16'h0000, 4'b0001, "R7");
        step(4'b1000, 16'h3000, 4'b0000, "R7");
        step(4'b0000, 16'h0000, 4'b1000, "R7");
        // R10: busy load not re-granted; stray done on idle ALU ignored
        step(4'b0001, 16'h0001, 4'b0000, "R10");
        step(4'b0001, 16'h0001, 4'b0100, "R10");
        step(4'b0000, 16'h0000, 4'b0001, "R10");
        // R8: drive forward counter 0 into saturation
        for (int k = 0; k < 17; k++) begin
            step(4'b0001, 16'h0001, 4'b0000, "R8");
            step(4'b0000, 16'h0000, 4'b0001, "R8");
        end
        // R9 at the top: push and pop together keep 15
        step(4'b0001, 16'h0001, 4'b0000, "R9");
        step(4'b0010, 16'h0080, 4'b0001, "R9");
        step(4'b0000, 16'h0000, 4'b0010, "R9");
        // R11: store gives backward token, ALU no-op 0110 relays it to GEMM
        step(4'b0100, 16'h0600, 4'b0000, "R11");
        step(4'b1000, 16'h4000, 4'b0000, "R11");
        step(4'b0000, 16'h0000, 4'b1000, "R11");
        step(4'b0100, 16'h0600, 4'b0000, "R11");
        step(4'b0000, 16'h0000, 4'b0100, "R11");
        step(4'b0010, 16'h0020, 4'b0000, "R11");
        step(4'b0000, 16'h0000, 4'b0010, "R11");
        step(4'b0000, 16'h0000, 4'b0000, "R1");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule